// File: doc/BRIEF.md
# Triangular Spread-Spectrum Profile Controller

This block takes a two-bit frequency/spread selection and, from a reference clock, produces the control words a downstream frequency synthesiser needs. These are a base divider code for the chosen output frequency, a signed modulation offset, and a flag that shows whether spread is active. The selection is captured once, on the first clock edge after reset is released, and held from then on. Changes on the select pins after that have no effect until the next reset.

One of the four selections runs the 100 MHz base with a down-only spread of -0.5%. In that mode an up/down counter walks a position from zero to a parameterised number of steps and back again. Each position is held for a parameterised number of clocks. The offset is the position times a step weight, negated, so the resulting triangle only ever lowers the frequency. The full depth, steps times step weight, stands for the -0.5% deviation in the synthesiser's offset units. The other three selections leave the offset at exactly zero.

Top module: `sss_profile_ctrl`

## Requirements
- R1: While reset is high, after the first clock edge, base_code equals CODE_100, spread_on is 0 and offset is 0.
- R2: The select value present at the first clock edge with reset low is captured. base_code and spread_on reflect it from the second such edge onward, and keep their reset values after the first edge.
- R3: Select mapping, with sel[1] as the high bit: 2'b00 gives CODE_100 with no spread; 2'b01 gives CODE_100 with spread; 2'b10 gives CODE_125 with no spread; 2'b11 gives CODE_200 with no spread.
- R4: After capture, changes on sel change neither base_code nor spread_on until reset is asserted again. Once high, spread_on stays high until reset.
- R5: Whenever spread_on is 0, offset is exactly 0.
- R6: offset never goes above 0 and never goes below -(STEPS*STEP_SIZE).
- R7: Between two consecutive samples, offset changes by 0 or by exactly STEP_SIZE in either direction. Each offset value is held for DWELL clocks.
- R8: The profile is a symmetric triangle. Let m be the number of clock edges since spread_on rose, and let j = (m / DWELL) mod (2*STEPS). Then offset equals -j*STEP_SIZE for j <= STEPS and -(2*STEPS-j)*STEP_SIZE otherwise. This reaches full depth at m = STEPS*DWELL and returns to 0 at m = 2*STEPS*DWELL.
- R9: base_code is constant from the second edge after reset release until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 2 | Frequency/spread selection, captured after reset |
| base_code | output | CODE_W | Divider code for the selected base frequency |
| offset | output | OFS_W | Signed modulation offset, zero or negative |
| spread_on | output | 1 | High while the triangular spread is applied |

## Verification
The bench builds the block with STEPS=4, STEP_SIZE=3, DWELL=3 and an 8-bit offset, so one full triangle lasts 24 clocks. Random runs of up to about 130 clocks therefore cross several peaks and valleys, and both turnarounds are exercised. The short dwell also makes the hold time between steps visible, and the small depth keeps every offset value within easy reach of a per-cycle model. Random reselection after capture, and select changes during reset, exercise the one-shot capture for all four codes.

// File: rtl/sss_pkg.sv
package sss_pkg;
  typedef enum logic [1:0] {
    SEL_BASE   = 2'b00,
    SEL_SPREAD = 2'b01,
    SEL_MID    = 2'b10,
    SEL_HIGH   = 2'b11
  } sel_e;
endpackage

// File: rtl/sss_mode_latch.sv
module sss_mode_latch
  import sss_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] sel,
  output sel_e       mode,
  output logic       captured
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= SEL_BASE;
      captured <= 1'b0;
    end else if (!captured) begin
      mode     <= sel_e'(sel);
      captured <= 1'b1;
    end
  end

  // R4: the captured selection is frozen until reset
  p_capture_hold_r4: assert property (@(posedge clk) disable iff (rst)
    captured |=> (captured && $stable(mode)));
endmodule

// File: rtl/sss_code_map.sv
module sss_code_map
  import sss_pkg::*;
#(
  parameter int CODE_W   = 12,
  parameter int CODE_100 = 400,
  parameter int CODE_125 = 500,
  parameter int CODE_200 = 800
) (
  input  logic              clk,
  input  logic              rst,
  input  sel_e              mode,
  input  logic              mode_vld,
  output logic [CODE_W-1:0] base_code,
  output logic              spread_on
);
  logic [CODE_W-1:0] code_d;

  always_comb begin
    unique case (mode)
      SEL_MID:  code_d = CODE_W'(CODE_125);
      SEL_HIGH: code_d = CODE_W'(CODE_200);
      default:  code_d = CODE_W'(CODE_100);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_code <= CODE_W'(CODE_100);
      spread_on <= 1'b0;
    end else if (mode_vld) begin
      base_code <= code_d;
      spread_on <= (mode == SEL_SPREAD);
    end
  end

  // R9: base code holds once the captured mode has been applied
  p_base_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (mode_vld && $past(mode_vld) && $past(mode_vld, 2)) |-> $stable(base_code));
endmodule

// File: rtl/sss_tri_gen.sv
module sss_tri_gen #(
  parameter int STEPS     = 32,
  parameter int STEP_SIZE = 4,
  parameter int DWELL     = 16,
  parameter int OFS_W     = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  output logic signed [OFS_W-1:0] offset
);
  localparam int PW     = $clog2(STEPS + 1);
  localparam int CW     = (DWELL > 1) ? $clog2(DWELL) : 1;
  localparam int MAXDEV = STEPS * STEP_SIZE;

  logic [PW-1:0] pos_q, pos_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          deepen_q, deepen_d;
  logic          step;

  always_comb begin
    pos_d    = pos_q;
    deepen_d = deepen_q;
    step     = (cnt_q == CW'(DWELL - 1));
    cnt_d    = step ? '0 : cnt_q + 1'b1;
    if (!en) begin
      pos_d    = '0;
      deepen_d = 1'b1;
      cnt_d    = '0;
    end else if (step) begin
      if (deepen_q) begin
        pos_d = pos_q + 1'b1;
        if (pos_d == PW'(STEPS)) deepen_d = 1'b0;
      end else begin
        pos_d = pos_q - 1'b1;
        if (pos_d == '0) deepen_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q    <= '0;
      cnt_q    <= '0;
      deepen_q <= 1'b1;
      offset   <= '0;
    end else begin
      pos_q    <= pos_d;
      cnt_q    <= cnt_d;
      deepen_q <= deepen_d;
      offset   <= OFS_W'(-(int'(pos_d) * STEP_SIZE));
    end
  end

  // R6: offset stays within [-MAXDEV, 0]
  p_offset_bounds_r6: assert property (@(posedge clk) disable iff (rst)
    (int'(offset) <= 0) && (int'(offset) >= -MAXDEV));

  // R7: any change while running is exactly one step
  p_step_size_r7: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && offset != $past(offset)) |->
      ((int'(offset) - int'($past(offset)) == STEP_SIZE) ||
       (int'(offset) - int'($past(offset)) == -STEP_SIZE)));
endmodule

// File: rtl/sss_profile_ctrl.sv
module sss_profile_ctrl
  import sss_pkg::*;
#(
  parameter int CODE_W    = 12,
  parameter int CODE_100  = 400,
  parameter int CODE_125  = 500,
  parameter int CODE_200  = 800,
  parameter int STEPS     = 32,
  parameter int STEP_SIZE = 4,
  parameter int DWELL     = 16,
  parameter int OFS_W     = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              sel,
  output logic [CODE_W-1:0]       base_code,
  output logic signed [OFS_W-1:0] offset,
  output logic                    spread_on
);
  sel_e mode;
  logic captured;

  sss_mode_latch u_latch (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .mode     (mode),
    .captured (captured)
  );

  sss_code_map #(
    .CODE_W   (CODE_W),
    .CODE_100 (CODE_100),
    .CODE_125 (CODE_125),
    .CODE_200 (CODE_200)
  ) u_map (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .mode_vld  (captured),
    .base_code (base_code),
    .spread_on (spread_on)
  );

  sss_tri_gen #(
    .STEPS     (STEPS),
    .STEP_SIZE (STEP_SIZE),
    .DWELL     (DWELL),
    .OFS_W     (OFS_W)
  ) u_tri (
    .clk    (clk),
    .rst    (rst),
    .en     (spread_on),
    .offset (offset)
  );

  // R5: no modulation without spread
  p_zero_when_off_r5: assert property (@(posedge clk) disable iff (rst)
    !spread_on |-> (offset == '0));

  // R4: spread flag is sticky until reset
  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    spread_on |=> spread_on);
endmodule

// File: tb/sss_profile_ctrl_tb.sv
`timescale 1ns/1ps
module sss_profile_ctrl_tb;
  localparam int CODE_W = 12, C100 = 400, C125 = 500, C200 = 800;
  localparam int ST = 4, SS = 3, DW = 3, OW = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] sel = 2'b00;
  logic [CODE_W-1:0] base_code;
  logic signed [OW-1:0] offset;
  logic spread_on;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  sss_profile_ctrl #(.CODE_W(CODE_W), .CODE_100(C100), .CODE_125(C125),
    .CODE_200(C200), .STEPS(ST), .STEP_SIZE(SS), .DWELL(DW), .OFS_W(OW)) u_dut (
    .clk(clk), .rst(rst), .sel(sel), .base_code(base_code),
    .offset(offset), .spread_on(spread_on));

  function automatic int exp_base(input logic [1:0] s);
    case (s)
      2'b10:   return C125;
      2'b11:   return C200;
      default: return C100;
    endcase
  endfunction

  function automatic int exp_off(input int m);
    int j;
    j = (m / DW) % (2 * ST);
    return (j <= ST) ? -j * SS : -(2 * ST - j) * SS;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic trial(input logic [1:0] s, input int len, input bit resel);
    int prev;
    rst = 1'b1;
    repeat (3) begin
      @(negedge clk);
      sel = 2'($urandom);
      chk(base_code == C100, "R1 base in reset", int'(base_code), C100);
      chk(spread_on == 1'b0, "R1 spread in reset", int'(spread_on), 0);
      chk(offset == 0, "R1 offset in reset", int'(offset), 0);
    end
    sel = s;
    rst = 1'b0;
    @(negedge clk);
    chk(base_code == C100 && !spread_on, "R2 defaults after first edge",
        int'(base_code), C100);
    prev = 0;
    for (int m = 0; m < len; m++) begin
      @(negedge clk);
      if (resel && m == 2) sel = ~s;
      if (resel && m > 2) sel = 2'($urandom);
      chk(int'(base_code) == exp_base(s), "R3 R4 R9 base code",
          int'(base_code), exp_base(s));
      chk(spread_on == (s == 2'b01), "R3 R4 spread flag",
          int'(spread_on), int'(s == 2'b01));
      if (s != 2'b01) begin
        chk(offset == 0, "R5 offset zero without spread", int'(offset), 0);
      end else begin
        chk(int'(offset) == exp_off(m), "R8 triangle value", int'(offset), exp_off(m));
        chk(int'(offset) <= 0 && int'(offset) >= -ST * SS, "R6 offset bounds",
            int'(offset), -ST * SS);
        if (m > 0 && int'(offset) != prev)
          chk((int'(offset) - prev == SS || prev - int'(offset) == SS) && (m % DW == 0),
              "R7 step size and dwell", int'(offset) - prev, SS);
        if (m == ST * DW)
          chk(int'(offset) == -ST * SS, "R8 full depth", int'(offset), -ST * SS);
        if (m == 2 * ST * DW)
          chk(offset == 0, "R8 symmetric return", int'(offset), 0);
      end
      prev = int'(offset);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int k = 0; k < 4; k++) trial(2'(k), 60, 1'b0);
    trial(2'b01, 80, 1'b1);
    trial(2'b11, 20, 1'b1);
    for (int k = 0; k < 40; k++)
      trial(2'($urandom), 10 + int'($urandom % 120), 1'($urandom));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule